// File: doc/BRIEF.md
# Front Panel Instruction-Jamming Controller

This block lets a front panel examine and deposit memory on an 8080-style processor without the processor ever running a store. It sits between the panel's command pulses and address switches on one side and the processor's data input and the system bus buffers on the other. To examine a location, it places a jump opcode and then the switch address, low byte first, onto a private data path into the processor. Each byte is fed on one processor read, and the system data bus is isolated while this happens. To step to the next location, it feeds a single all-zero byte (NOP), so the processor's own program counter moves the address forward by one.

A deposit never involves a processor write. The block waits until the processor is parked in its wait state. It then enables the switch data onto the bus, strobes the memory write for one cycle, releases the enable, and only after that feeds the NOP that lets the processor move on. Deposit-next runs the other way round: it steps first with a NOP and then writes at the new address. The buffer direction output can be turned around by the processor's write strobe, by the panel's switch enable, or by reset, each through its own path.

Top module: `fp_jam_ctrl`

## Requirements
- R1: While reset is asserted and after it is released: `busy`=0, `buf_cs_n`=0, `mem_wr`=0, `sw_oe`=0, `jam_data`=all ones (0xFF).
- R2: An examine command presents 0xC3, then bits 7:0 of the address, then bits 15:8, one byte per consumed read. `buf_cs_n` is 1 throughout, and the block returns to idle after the third byte.
- R3: An examine-next command presents 0x00 for one consumed fetch read and then returns to idle.
- R4: A deposit waits in a parked step (`busy`=1, `buf_cs_n`=0) until `cpu_wait`=1. It then runs one cycle with `sw_oe`=1 and `mem_wr`=0, one cycle with `sw_oe`=1 and `mem_wr`=1, and one cycle with both at 0. After that it presents 0x00 until a fetch read consumes it.
- R5: A deposit-next first presents 0x00 until a fetch read consumes it. It then runs the parked step and the three-cycle write of R4, and returns to idle.
- R6: A presented byte is consumed on the clock edge where `cpu_dbin` falls. The value of `cpu_fetch` during that read must match the byte's kind: 1 for the jump and NOP opcodes, 0 for address bytes. A read of the wrong kind leaves the same byte presented.
- R7: `buf_cs_n` is 1 exactly while a byte is presented, and 0 at all other times, including the write cycles.
- R8: `buf_dir_out` is 1 whenever `rst_n`=0, `cpu_wr_n`=0 or `sw_oe`=1, and 0 otherwise.
- R9: Commands that arrive while `busy`=1 are ignored. This includes a command that arrives on the same edge that consumes the final byte.
- R10: When several commands arrive in the same idle cycle, exactly one is taken, in this priority order: examine, examine-next, deposit, deposit-next.
- R11: The switch address is captured when an examine is accepted. Switch changes after that do not alter the bytes presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_addr | input | ADDR_W | Address switch levels |
| cmd_exam | input | 1 | Examine command pulse |
| cmd_exam_nxt | input | 1 | Examine-next command pulse |
| cmd_dep | input | 1 | Deposit command pulse |
| cmd_dep_nxt | input | 1 | Deposit-next command pulse |
| cpu_fetch | input | 1 | Processor status: current read is an instruction fetch |
| cpu_dbin | input | 1 | Processor data-in strobe |
| cpu_wait | input | 1 | Processor is in its wait state |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| jam_data | output | DATA_W | Byte on the private path into the processor |
| buf_cs_n | output | 1 | Bus buffer select, 1 isolates the system data bus |
| buf_dir_out | output | 1 | Buffer direction, 1 turns the buffers toward the bus |
| mem_wr | output | 1 | Memory write strobe |
| sw_oe | output | 1 | Enable for switch data onto the bus |
| busy | output | 1 | A command sequence is in progress |

## Verification
Two things can fall on the same clock edge: a new panel command, and the consumption of the last presented byte, which ends the sequence. The bench raises the command on exactly that edge, as `cpu_dbin` falls. It then checks that `busy` drops and `buf_cs_n` returns low with the idle byte on `jam_data`, which shows that the late command was not taken. The other coincidence is two or more command pulses in one cycle. All fifteen combinations are swept, and the winner is identified from the presented byte and from how the block behaves after one fetch read.

// File: rtl/fp_jam_pkg.sv
package fp_jam_pkg;

   localparam int N_CMD = 4;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_J_OPC   = 3'd1,
      ST_J_ADR   = 3'd2,
      ST_J_NOP   = 3'd3,
      ST_W_PARK  = 3'd4,
      ST_W_SETUP = 3'd5,
      ST_W_STRB  = 3'd6,
      ST_W_REL   = 3'd7
   } fp_st_e;

   // index order equals arbitration priority (0 highest)
   typedef enum logic [1:0] {
      OP_EXAM = 2'd0,
      OP_EXNX = 2'd1,
      OP_DEP  = 2'd2,
      OP_DPNX = 2'd3
   } fp_op_e;

endpackage

// File: rtl/fp_cmd_arb.sv
module fp_cmd_arb #(
   parameter int N_REQ = 4,
   localparam int IW   = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
   input  logic [N_REQ-1:0] req,
   input  logic             idle,
   output logic [N_REQ-1:0] grant,
   output logic [IW-1:0]    win_idx,
   output logic             take
);

   if (N_REQ < 1) begin : g_bad_n
      $error("fp_cmd_arb: N_REQ must be at least 1");
   end

   logic [N_REQ-1:0] pick;
   logic             found;

   // fixed priority, lowest index wins
   always_comb begin
      pick    = '0;
      found   = 1'b0;
      win_idx = '0;
      for (int i = 0; i < N_REQ; i++) begin
         if (!found && req[i]) begin
            found   = 1'b1;
            pick[i] = 1'b1;
            win_idx = IW'(i);
         end
      end
   end

   assign grant = idle ? pick : '0;
   assign take  = idle & found;

endmodule

// File: rtl/fp_rd_watch.sv
module fp_rd_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic cpu_dbin,
   input  logic cpu_fetch,
   output logic rd_done,
   output logic rd_fetch
);

   logic dbin_q;
   logic fetch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dbin_q  <= 1'b0;
         fetch_q <= 1'b0;
      end else begin
         dbin_q  <= cpu_dbin;
         fetch_q <= cpu_fetch;
      end
   end

   // read completes when the data-in strobe drops
   assign rd_done  = dbin_q & ~cpu_dbin;
   assign rd_fetch = fetch_q;

endmodule

// File: rtl/fp_seq_fsm.sv
module fp_seq_fsm
   import fp_jam_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   localparam int N_AB  = ADDR_W / DATA_W,
   localparam int IDX_W = (N_AB > 1) ? $clog2(N_AB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  fp_op_e            op,
   input  logic [ADDR_W-1:0] sw_addr,
   input  logic              rd_done,
   input  logic              rd_fetch,
   input  logic              cpu_wait,
   output fp_st_e            st,
   output logic [IDX_W-1:0]  byte_idx,
   output logic [ADDR_W-1:0] addr_q,
   output logic              sw_oe,
   output logic              mem_wr,
   output logic              busy
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_AB - 1);

   fp_op_e op_q;
   logic   eat_opc;
   logic   eat_adr;

   assign eat_opc = rd_done &  rd_fetch;
   assign eat_adr = rd_done & ~rd_fetch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_q     <= OP_EXAM;
         addr_q   <= '0;
         byte_idx <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (take) begin
                  op_q     <= op;
                  addr_q   <= sw_addr;
                  byte_idx <= '0;
                  case (op)
                     OP_EXAM: st <= ST_J_OPC;
                     OP_DEP:  st <= ST_W_PARK;
                     default: st <= ST_J_NOP;
                  endcase
               end
            end
            ST_J_OPC: begin
               if (eat_opc) st <= ST_J_ADR;
            end
            ST_J_ADR: begin
               if (eat_adr) begin
                  if (byte_idx == LAST_IDX) st <= ST_IDLE;
                  else byte_idx <= byte_idx + IDX_W'(1);
               end
            end
            ST_J_NOP: begin
               if (eat_opc) st <= (op_q == OP_DPNX) ? ST_W_PARK : ST_IDLE;
            end
            ST_W_PARK: begin
               if (cpu_wait) st <= ST_W_SETUP;
            end
            ST_W_SETUP: st <= ST_W_STRB;
            ST_W_STRB:  st <= ST_W_REL;
            ST_W_REL:   st <= (op_q == OP_DEP) ? ST_J_NOP : ST_IDLE;
            default:    st <= ST_IDLE;
         endcase
      end
   end

   assign sw_oe  = (st == ST_W_SETUP) || (st == ST_W_STRB);
   assign mem_wr = (st == ST_W_STRB);
   assign busy   = (st != ST_IDLE);

   AST_STRB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr); // R4

   AST_STRB_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_wr) |-> $past(sw_oe)); // R4

   AST_OE_DROPS_AFTER_STRB: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr) |-> !sw_oe); // R4

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(addr_q)); // R11

endmodule

// File: rtl/fp_bus_ctl.sv
module fp_bus_ctl
   import fp_jam_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] JMP_OPC   = 8'hC3,
   parameter logic [DATA_W-1:0] NOP_OPC   = '0,
   parameter logic [DATA_W-1:0] IDLE_BYTE = '1,
   localparam int N_AB  = ADDR_W / DATA_W,
   localparam int IDX_W = (N_AB > 1) ? $clog2(N_AB) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fp_st_e            st,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic              cpu_wr_n,
   input  logic              sw_oe,
   output logic [DATA_W-1:0] jam_data,
   output logic              buf_cs_n,
   output logic              buf_dir_out
);

   logic [DATA_W-1:0] abyte [N_AB];

   // slice the held address into bytes, low byte at index 0
   for (genvar g = 0; g < N_AB; g++) begin : g_slice
      assign abyte[g] = addr_q[g*DATA_W +: DATA_W];
   end

   logic jam_on;

   always_comb begin
      jam_on   = 1'b1;
      jam_data = IDLE_BYTE;
      case (st)
         ST_J_OPC: jam_data = JMP_OPC;
         ST_J_ADR: jam_data = abyte[byte_idx];
         ST_J_NOP: jam_data = NOP_OPC;
         default:  jam_on   = 1'b0;
      endcase
   end

   assign buf_cs_n    = jam_on;
   // three independent sources may turn the buffers around
   assign buf_dir_out = ~rst_n | ~cpu_wr_n | sw_oe;

   AST_OE_NOT_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      sw_oe |-> !buf_cs_n); // R7

   AST_OE_TURNS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      sw_oe |-> buf_dir_out); // R8

   AST_WR_TURNS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_wr_n |-> buf_dir_out); // R8

endmodule

// File: rtl/fp_jam_ctrl.sv
module fp_jam_ctrl
   import fp_jam_pkg::*;
#(
   parameter int              ADDR_W    = 16,
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] JMP_OPC   = 8'hC3,
   parameter logic [DATA_W-1:0] NOP_OPC   = '0,
   parameter logic [DATA_W-1:0] IDLE_BYTE = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] sw_addr,
   input  logic              cmd_exam,
   input  logic              cmd_exam_nxt,
   input  logic              cmd_dep,
   input  logic              cmd_dep_nxt,
   input  logic              cpu_fetch,
   input  logic              cpu_dbin,
   input  logic              cpu_wait,
   input  logic              cpu_wr_n,
   output logic [DATA_W-1:0] jam_data,
   output logic              buf_cs_n,
   output logic              buf_dir_out,
   output logic              mem_wr,
   output logic              sw_oe,
   output logic              busy
);

   localparam int N_AB  = ADDR_W / DATA_W;
   localparam int IDX_W = (N_AB > 1) ? $clog2(N_AB) : 1;
   localparam int OIW   = $clog2(N_CMD);

   if (DATA_W < 8) begin : g_bad_dw
      $error("fp_jam_ctrl: DATA_W must hold an opcode (>= 8)");
   end
   if (ADDR_W % DATA_W != 0) begin : g_bad_aw
      $error("fp_jam_ctrl: ADDR_W must be a whole number of bytes");
   end

   logic [N_CMD-1:0] cmd_vec;
   logic [N_CMD-1:0] grant;
   logic [OIW-1:0]   win_idx;
   logic             take;
   fp_op_e           op;
   fp_st_e           st;
   logic [IDX_W-1:0] byte_idx;
   logic [ADDR_W-1:0] addr_q;
   logic             rd_done;
   logic             rd_fetch;

   assign cmd_vec = {cmd_dep_nxt, cmd_dep, cmd_exam_nxt, cmd_exam};
   assign op      = fp_op_e'(win_idx);

   fp_cmd_arb #(.N_REQ(N_CMD)) i_arb (
      .req     (cmd_vec),
      .idle    (~busy),
      .grant   (grant),
      .win_idx (win_idx),
      .take    (take)
   );

   fp_rd_watch i_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_dbin  (cpu_dbin),
      .cpu_fetch (cpu_fetch),
      .rd_done   (rd_done),
      .rd_fetch  (rd_fetch)
   );

   fp_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .op       (op),
      .sw_addr  (sw_addr),
      .rd_done  (rd_done),
      .rd_fetch (rd_fetch),
      .cpu_wait (cpu_wait),
      .st       (st),
      .byte_idx (byte_idx),
      .addr_q   (addr_q),
      .sw_oe    (sw_oe),
      .mem_wr   (mem_wr),
      .busy     (busy)
   );

   fp_bus_ctl #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .JMP_OPC   (JMP_OPC),
      .NOP_OPC   (NOP_OPC),
      .IDLE_BYTE (IDLE_BYTE)
   ) i_bus (
      .clk         (clk),
      .rst_n       (rst_n),
      .st          (st),
      .byte_idx    (byte_idx),
      .addr_q      (addr_q),
      .cpu_wr_n    (cpu_wr_n),
      .sw_oe       (sw_oe),
      .jam_data    (jam_data),
      .buf_cs_n    (buf_cs_n),
      .buf_dir_out (buf_dir_out)
   );

   AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R10

   AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy); // R9

endmodule

// File: tb/test_fp_jam_ctrl.sv
`timescale 1ns/1ps
module test_fp_jam_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] sw_addr = '0;
   logic        cmd_exam = 0, cmd_exam_nxt = 0, cmd_dep = 0, cmd_dep_nxt = 0;
   logic        cpu_fetch = 0, cpu_dbin = 0, cpu_wait = 0, cpu_wr_n = 1;
   logic [7:0]  jam_data;
   logic        buf_cs_n, buf_dir_out, mem_wr, sw_oe, busy;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   fp_jam_ctrl i_fp_jam_ctrl (
      .clk(clk), .rst_n(rst_n), .sw_addr(sw_addr),
      .cmd_exam(cmd_exam), .cmd_exam_nxt(cmd_exam_nxt),
      .cmd_dep(cmd_dep), .cmd_dep_nxt(cmd_dep_nxt),
      .cpu_fetch(cpu_fetch), .cpu_dbin(cpu_dbin),
      .cpu_wait(cpu_wait), .cpu_wr_n(cpu_wr_n),
      .jam_data(jam_data), .buf_cs_n(buf_cs_n), .buf_dir_out(buf_dir_out),
      .mem_wr(mem_wr), .sw_oe(sw_oe), .busy(busy)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic nclk();
      @(negedge clk);
   endtask

   // bit0 examine, bit1 examine-next, bit2 deposit, bit3 deposit-next
   task automatic pulse(input logic [3:0] m);
      {cmd_dep_nxt, cmd_dep, cmd_exam_nxt, cmd_exam} = m;
      nclk();
      {cmd_dep_nxt, cmd_dep, cmd_exam_nxt, cmd_exam} = '0;
   endtask

   task automatic rd(input logic f);
      cpu_fetch = f;
      cpu_dbin  = 1'b1;
      nclk();
      cpu_dbin  = 1'b0;
      nclk();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      nclk();
      chk("R8 dir during reset", buf_dir_out, 1);
      chk("R1 busy in reset", busy, 0);
      nclk();
      rst_n = 1'b1;
      nclk();
   endtask

   task automatic idle_chk(input string tag);
      chk({tag, " busy"}, busy, 0);
      chk({tag, " cs_n"}, buf_cs_n, 0);
      chk({tag, " jam"}, jam_data, 8'hFF);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      nclk();
      do_reset();
      // R1 reset state
      idle_chk("R1");
      chk("R1 mem_wr", mem_wr, 0);
      chk("R1 sw_oe", sw_oe, 0);
      chk("R8 dir idle", buf_dir_out, 0);
      cpu_wr_n = 1'b0;
      #1 chk("R8 dir from cpu write", buf_dir_out, 1);
      nclk();
      cpu_wr_n = 1'b1;
      #1 chk("R8 dir released", buf_dir_out, 0);
      nclk();

      // R2 / R11 / R6 examine sweep
      for (int k = 0; k < 16; k++) begin
         logic [15:0] a;
         a = (16'h8421 * 16'(k + 1)) ^ (16'h0001 << k);
         sw_addr = a;
         pulse(4'b0001);
         chk("R2 opcode", jam_data, 8'hC3);
         chk("R7 isolated opc", buf_cs_n, 1);
         if (k == 3) begin
            rd(1'b0);
            chk("R6 wrong-kind read keeps opcode", jam_data, 8'hC3);
         end
         rd(1'b1);
         chk("R2 low byte", jam_data, a[7:0]);
         sw_addr = ~a;
         if (k == 5) begin
            rd(1'b1);
            chk("R6 fetch read keeps addr byte", jam_data, a[7:0]);
         end
         rd(1'b0);
         chk("R11 high byte latched", jam_data, a[15:8]);
         chk("R7 isolated addr", buf_cs_n, 1);
         rd(1'b0);
         idle_chk("R2 done");
      end

      // R3 examine-next, with same-edge command (R9)
      pulse(4'b0010);
      chk("R3 nop", jam_data, 8'h00);
      chk("R3 busy", busy, 1);
      cpu_fetch = 1'b1;
      cpu_dbin = 1'b1;
      nclk();
      cpu_dbin = 1'b0;
      cmd_exam = 1'b1;
      nclk();
      cmd_exam = 1'b0;
      idle_chk("R9 same-edge command ignored");
      nclk();
      idle_chk("R3 R9 still idle");

      // R4 deposit
      cpu_wait = 1'b0;
      pulse(4'b0100);
      chk("R4 parked busy", busy, 1);
      chk("R7 parked cs_n", buf_cs_n, 0);
      chk("R4 parked oe", sw_oe, 0);
      pulse(4'b0001);
      chk("R9 busy ignores examine", buf_cs_n, 0);
      cpu_wait = 1'b1;
      nclk();
      chk("R4 setup oe", sw_oe, 1);
      chk("R4 setup wr", mem_wr, 0);
      chk("R8 dir from oe", buf_dir_out, 1);
      nclk();
      chk("R4 strobe oe", sw_oe, 1);
      chk("R4 strobe wr", mem_wr, 1);
      chk("R7 strobe cs_n", buf_cs_n, 0);
      nclk();
      chk("R4 release oe", sw_oe, 0);
      chk("R4 release wr", mem_wr, 0);
      nclk();
      chk("R4 nop after write", jam_data, 8'h00);
      chk("R4 nop cs_n", buf_cs_n, 1);
      cpu_wait = 1'b0;
      rd(1'b1);
      idle_chk("R4 done");

      // R5 deposit-next
      pulse(4'b1000);
      chk("R5 nop first", jam_data, 8'h00);
      chk("R5 no write yet", sw_oe, 0);
      rd(1'b1);
      chk("R5 parked busy", busy, 1);
      chk("R5 parked cs_n", buf_cs_n, 0);
      cpu_wait = 1'b1;
      nclk();
      chk("R5 setup oe", sw_oe, 1);
      nclk();
      chk("R5 strobe wr", mem_wr, 1);
      nclk();
      chk("R5 release", {sw_oe, mem_wr}, 0);
      nclk();
      cpu_wait = 1'b0;
      idle_chk("R5 done");

      // R10 priority sweep over every non-empty combination
      for (int m = 1; m < 16; m++) begin
         int w;
         w = 0;
         while (((m >> w) & 1) == 0) w++;
         do_reset();
         pulse(4'(m));
         chk("R10 cs_n", buf_cs_n, (w != 2) ? 1 : 0);
         chk("R10 byte", jam_data, (w == 0) ? 8'hC3 : (w == 2) ? 8'hFF : 8'h00);
         rd(1'b1);
         chk("R10 busy after fetch", busy, (w != 1) ? 1 : 0);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule